// File: doc/BRIEF.md
# Four-Plane Blit Alignment Shifter

This block sits in the datapath of a planar graphics blitter that keeps four bit planes. When a blit copies a span whose first source bit does not line up with the first destination bit, each 16-bit word must be realigned. The realigned word combines the freshly shifted bits with the bits that spilled over from the previous word of the same plane. The block keeps one carry-over word per plane. Each shift strobe names a plane and presents a word. One clock later the block returns the aligned word, and at the same edge it stores the new spill for that plane. Read fetches and CPU-supplied write data both pass through the same strobe.

The amount and direction of the shift come from three control fields: a 4-bit source bit offset, a 4-bit destination bit offset, and a direction flag. When the source offset is larger than the destination offset, the first word of the blit only fills the pipeline. A separate priming strobe feeds that word through plane 0 and copies the resulting spill into all four planes. It then marks the blit as primed, and no aligned word is produced. A blit that was not primed clears every carry-over word when its first word arrives. A blit-start strobe re-arms the priming logic for the next blit.

Top module: `blit_align_shifter`

## Requirements
- R1: After reset (rst_n low at a clock edge), out_vld_o and primed_o are 0 and all four carry-over words are 0.
- R2: Let main = dst - src when dst >= src, and 16 - (src - dst) otherwise. Let spill = 16 - main. A shift by 16 gives 0. The offsets are read from ctrl_src_i and ctrl_dst_i. ctrl_desc_i = 0 selects ascending direction, and 1 selects descending.
- R3: Ascending, dst >= src: out = (val << (dst-src)) | carry[plane], and carry[plane] becomes val >> (16-(dst-src)). With equal offsets, the carry becomes 0 and out = val | carry.
- R4: Ascending, src > dst with L = src-dst: out = (val << (16-L)) | carry[plane], and carry[plane] becomes val >> L.
- R5: Descending uses the same amounts with every shift reversed: out = (val >> main) | carry[plane], and carry[plane] becomes val << spill.
- R6: A shift updates only the carry-over word of the plane given by shift_plane_i. The other three are kept.
- R7: A shift with first_word_i = 1 while primed_o = 0 treats every carry-over word as 0. The output uses a zero carry, the other three planes are cleared, and the shifted plane takes its new spill, all in the same cycle.
- R8: A priming strobe is accepted when src > dst, primed_o = 0, and neither shift_vld_i nor blit_start_i is high. It shifts prime_data_i through plane 0 and writes that spill to all four carry-over words. primed_o becomes 1 and out_vld_o stays 0.
- R9: A priming strobe that is not accepted changes no carry-over word and does not change primed_o. A shift with first_word_i = 1 while primed keeps the carries.
- R10: blit_start_i clears primed_o at the next edge and leaves the carry-over words unchanged.
- R11: out_vld_o is high in exactly the cycle after a shift strobe. In that cycle out_plane_o and out_data_o hold that strobe's plane and aligned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_src_i | input | 4 | Source bit offset |
| ctrl_dst_i | input | 4 | Destination bit offset |
| ctrl_desc_i | input | 1 | 1 = descending direction |
| blit_start_i | input | 1 | Re-arm priming for a new blit |
| shift_vld_i | input | 1 | Shift strobe |
| shift_plane_i | input | 2 | Plane index of the strobe |
| shift_data_i | input | 16 | Word to align |
| first_word_i | input | 1 | Strobe carries the blit's first word |
| prime_vld_i | input | 1 | Priming strobe |
| prime_data_i | input | 16 | Word used for priming |
| out_vld_o | output | 1 | Aligned word valid |
| out_plane_o | output | 2 | Plane of the aligned word |
| out_data_o | output | 16 | Aligned word |
| primed_o | output | 1 | Current blit has been primed |

## Verification
The first-word shift is the point where two functions fall in the same cycle. Clearing all carry-over words and loading the new spill of the shifted plane happen at one edge, and the load must win for its own plane while the clear must win for the other three. The bench first fills all four planes with known spills. It then issues an unprimed first word on one plane and judges the result through later non-first shifts. The shifted plane must show only the spill of the first word, and each other plane must show a zero carry. A second collision, a priming strobe that arrives in the same cycle as a shift, must leave primed_o low and the carries untouched.

// File: rtl/blit_align_pkg.sv
// Package: shared widths and types for the blit alignment shifter.
// Assumes a power-of-two word width so that offsets fit in $clog2 bits.
package blit_align_pkg;
    localparam int WORD_W = 16;
    localparam int PLANES = 4;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/blit_shift_core.sv
// Module: blit_shift_core
// Purely combinational funnel shift. It takes one word plus the carry-over of
// its plane and returns the aligned word and the spill for the next word.
// Assumes OFS_W = $clog2(WORD_W). A shift amount equal to WORD_W yields zero.
module blit_shift_core #(
    parameter int WORD_W = blit_align_pkg::WORD_W,
    parameter int OFS_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] val_i,
    input  logic [WORD_W-1:0] carry_i,
    input  logic [OFS_W-1:0]  src_i,
    input  logic [OFS_W-1:0]  dst_i,
    input  logic              desc_i,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] spill_o
);
    localparam int AMT_W = OFS_W + 1;
    localparam logic [AMT_W-1:0] FULL = AMT_W'(WORD_W);

    logic [AMT_W-1:0] src_x, dst_x, main_amt, spill_amt;

    // Derive the two complementary shift amounts from the offsets.
    always_comb begin
        src_x = AMT_W'(src_i);
        dst_x = AMT_W'(dst_i);
        if (dst_x >= src_x)
            main_amt = dst_x - src_x;
        else
            main_amt = FULL - (src_x - dst_x);
        spill_amt = FULL - main_amt;
    end

    // Shift toward the destination; the direction flag mirrors both shifts.
    always_comb begin
        if (desc_i) begin
            data_o  = (val_i >> main_amt) | carry_i;
            spill_o = val_i << spill_amt;
        end else begin
            data_o  = (val_i << main_amt) | carry_i;
            spill_o = val_i >> spill_amt;
        end
    end
endmodule

// File: rtl/blit_carry_bank.sv
// Module: blit_carry_bank
// Holds one carry-over word per plane. Priority per plane: broadcast,
// then the plane-selected load, then clear-all. Synchronous active-low reset.
module blit_carry_bank #(
    parameter int WORD_W = blit_align_pkg::WORD_W,
    parameter int PLANES = blit_align_pkg::PLANES,
    parameter int PIDX_W = $clog2(PLANES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear_all_i,
    input  logic                           load_en_i,
    input  logic [PIDX_W-1:0]              load_plane_i,
    input  logic [WORD_W-1:0]              load_val_i,
    input  logic                           bcast_en_i,
    input  logic [WORD_W-1:0]              bcast_val_i,
    output logic [PLANES-1:0][WORD_W-1:0]  carry_o
);
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        // Update this plane's carry-over word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                carry_o[p] <= '0;
            else if (bcast_en_i)
                carry_o[p] <= bcast_val_i;
            else if (load_en_i && (load_plane_i == PIDX_W'(p)))
                carry_o[p] <= load_val_i;
            else if (clear_all_i)
                carry_o[p] <= '0;
        end
    end
endmodule

// File: rtl/blit_align_shifter.sv
// Module: blit_align_shifter (top)
// Aligns source words to the destination bit position for four planes. It
// shares one funnel shifter between shift strobes and the priming strobe.
// Assumes the caller holds the control fields steady during a blit and pulses
// blit_start_i before each new blit.
module blit_align_shifter #(
    parameter int WORD_W = blit_align_pkg::WORD_W,
    parameter int PLANES = blit_align_pkg::PLANES,
    parameter int OFS_W  = $clog2(WORD_W),
    parameter int PIDX_W = $clog2(PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  ctrl_src_i,
    input  logic [OFS_W-1:0]  ctrl_dst_i,
    input  logic              ctrl_desc_i,
    input  logic              blit_start_i,
    input  logic              shift_vld_i,
    input  logic [PIDX_W-1:0] shift_plane_i,
    input  logic [WORD_W-1:0] shift_data_i,
    input  logic              first_word_i,
    input  logic              prime_vld_i,
    input  logic [WORD_W-1:0] prime_data_i,
    output logic              out_vld_o,
    output logic [PIDX_W-1:0] out_plane_o,
    output logic [WORD_W-1:0] out_data_o,
    output logic              primed_o
);
    logic [PLANES-1:0][WORD_W-1:0] carry_q;
    logic [PIDX_W-1:0]             sel_plane;
    logic [WORD_W-1:0]             sel_val, sel_carry, aligned, spill;
    logic                          first_clear, prime_ok;

    // Decide which strobe owns the shifter and whether a clear applies.
    always_comb begin
        first_clear = shift_vld_i && first_word_i && !primed_o;
        prime_ok    = prime_vld_i && !shift_vld_i && !blit_start_i &&
                      (ctrl_src_i > ctrl_dst_i) && !primed_o;
        sel_plane   = shift_vld_i ? shift_plane_i : '0;
        sel_val     = shift_vld_i ? shift_data_i : prime_data_i;
        sel_carry   = first_clear ? '0 : carry_q[sel_plane];
    end

    blit_shift_core #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_core (
        .val_i   (sel_val),
        .carry_i (sel_carry),
        .src_i   (ctrl_src_i),
        .dst_i   (ctrl_dst_i),
        .desc_i  (ctrl_desc_i),
        .data_o  (aligned),
        .spill_o (spill)
    );

    blit_carry_bank #(.WORD_W(WORD_W), .PLANES(PLANES), .PIDX_W(PIDX_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_all_i  (first_clear),
        .load_en_i    (shift_vld_i),
        .load_plane_i (shift_plane_i),
        .load_val_i   (spill),
        .bcast_en_i   (prime_ok),
        .bcast_val_i  (spill),
        .carry_o      (carry_q)
    );

    // Track whether the current blit has been primed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            primed_o <= 1'b0;
        else if (blit_start_i)
            primed_o <= 1'b0;
        else if (prime_ok)
            primed_o <= 1'b1;
    end

    // Register the aligned word and its plane for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o   <= 1'b0;
            out_plane_o <= '0;
            out_data_o  <= '0;
        end else begin
            out_vld_o <= shift_vld_i;
            if (shift_vld_i) begin
                out_plane_o <= shift_plane_i;
                out_data_o  <= aligned;
            end
        end
    end
endmodule

// File: rtl/blit_align_shifter_chk.sv
// Module: blit_align_shifter_chk
// Temporal checks on the shifter's strobes, flag and carry-over words.
// It is bound into every blit_align_shifter instance.
module blit_align_shifter_chk #(
    parameter int WORD_W = 16,
    parameter int PLANES = 4,
    parameter int OFS_W  = 4,
    parameter int PIDX_W = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [OFS_W-1:0]              ctrl_src_i,
    input logic [OFS_W-1:0]              ctrl_dst_i,
    input logic                          shift_vld_i,
    input logic [PIDX_W-1:0]             shift_plane_i,
    input logic                          prime_vld_i,
    input logic                          blit_start_i,
    input logic                          out_vld_o,
    input logic [PIDX_W-1:0]             out_plane_o,
    input logic                          primed_o,
    input logic [PLANES-1:0][WORD_W-1:0] carry_q
);
    p_vld_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld_i |=> out_vld_o);
    p_vld_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_vld_i |=> !out_vld_o);
    p_plane_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld_i |=> (out_plane_o == $past(shift_plane_i)));
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blit_start_i |=> !primed_o);
    p_prime_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_o) |-> $past(prime_vld_i && !shift_vld_i));
    p_prime_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_o) |-> (carry_q[0] == carry_q[1] && carry_q[1] == carry_q[2]
                             && carry_q[2] == carry_q[3]));
    p_zero_spill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_vld_i && ctrl_src_i == ctrl_dst_i && !prime_vld_i)
            |=> (carry_q[$past(shift_plane_i)] == '0));
endmodule

bind blit_align_shifter blit_align_shifter_chk #(
    .WORD_W(WORD_W), .PLANES(PLANES), .OFS_W(OFS_W), .PIDX_W(PIDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_src_i    (ctrl_src_i),
    .ctrl_dst_i    (ctrl_dst_i),
    .shift_vld_i   (shift_vld_i),
    .shift_plane_i (shift_plane_i),
    .prime_vld_i   (prime_vld_i),
    .blit_start_i  (blit_start_i),
    .out_vld_o     (out_vld_o),
    .out_plane_o   (out_plane_o),
    .primed_o      (primed_o),
    .carry_q       (carry_q)
);

// File: tb/blit_align_shifter_test.sv
// Directed bench for blit_align_shifter: one task per scenario, reference
// values computed from the requirement equations.
module blit_align_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ctrl_src_i = '0, ctrl_dst_i = '0;
    logic        ctrl_desc_i = 1'b0, blit_start_i = 1'b0;
    logic        shift_vld_i = 1'b0, first_word_i = 1'b0, prime_vld_i = 1'b0;
    logic [1:0]  shift_plane_i = '0;
    logic [15:0] shift_data_i = '0, prime_data_i = '0;
    logic        out_vld_o, primed_o;
    logic [1:0]  out_plane_o;
    logic [15:0] out_data_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] mc [4];
    logic        m_primed;

    always #10 clk = ~clk;

    blit_align_shifter uut (
        .clk(clk), .rst_n(rst_n), .ctrl_src_i(ctrl_src_i), .ctrl_dst_i(ctrl_dst_i),
        .ctrl_desc_i(ctrl_desc_i), .blit_start_i(blit_start_i),
        .shift_vld_i(shift_vld_i), .shift_plane_i(shift_plane_i),
        .shift_data_i(shift_data_i), .first_word_i(first_word_i),
        .prime_vld_i(prime_vld_i), .prime_data_i(prime_data_i),
        .out_vld_o(out_vld_o), .out_plane_o(out_plane_o),
        .out_data_o(out_data_o), .primed_o(primed_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    // Reference equations for one shift, written from the requirement text.
    task automatic model(input logic [15:0] val, input logic [15:0] cin,
                         output logic [15:0] eo, output logic [15:0] ec);
        int s, d, m, c;
        logic [31:0] w;
        s = int'(ctrl_src_i);
        d = int'(ctrl_dst_i);
        m = (d >= s) ? d - s : 16 - (s - d);
        c = 16 - m;
        w = {16'h0, val};
        if (ctrl_desc_i) begin
            eo = 16'(w >> m) | cin;
            ec = 16'(w << c);
        end else begin
            eo = 16'(w << m) | cin;
            ec = 16'(w >> c);
        end
    endtask

    task automatic set_ctrl(input int s, input int d, input logic desc);
        @(negedge clk);
        ctrl_src_i = 4'(s);
        ctrl_dst_i = 4'(d);
        ctrl_desc_i = desc;
    endtask

    task automatic do_shift(input string req, input int pl, input logic [15:0] val,
                            input logic first);
        logic [15:0] eo, ec, cin;
        if (first && !m_primed)
            for (int i = 0; i < 4; i++) mc[i] = '0;
        cin = mc[pl];
        model(val, cin, eo, ec);
        @(negedge clk);
        shift_vld_i = 1'b1; shift_plane_i = 2'(pl);
        shift_data_i = val; first_word_i = first;
        @(negedge clk);
        shift_vld_i = 1'b0; first_word_i = 1'b0;
        check({req, " vld"}, {15'h0, out_vld_o}, 16'h1);
        check({req, " plane"}, {14'h0, out_plane_o}, 16'(pl));
        check({req, " data"}, out_data_o, eo);
        mc[pl] = ec;
    endtask

    task automatic do_prime(input string req, input logic [15:0] val, input logic with_shift);
        logic [15:0] eo, ec;
        logic accept;
        accept = !with_shift && (ctrl_src_i > ctrl_dst_i) && !m_primed;
        @(negedge clk);
        prime_vld_i = 1'b1; prime_data_i = val;
        if (with_shift) begin
            shift_vld_i = 1'b1; shift_plane_i = 2'd1;
            shift_data_i = 16'h0; first_word_i = 1'b0;
        end
        @(negedge clk);
        prime_vld_i = 1'b0; shift_vld_i = 1'b0;
        if (accept) begin
            model(val, mc[0], eo, ec);
            for (int i = 0; i < 4; i++) mc[i] = ec;
            m_primed = 1'b1;
            check({req, " no output"}, {15'h0, out_vld_o}, 16'h0);
        end else if (with_shift) begin
            model(16'h0, mc[1], eo, ec);
            mc[1] = ec;
        end
        check({req, " primed"}, {15'h0, primed_o}, {15'h0, m_primed});
    endtask

    task automatic do_start();
        @(negedge clk);
        blit_start_i = 1'b1;
        @(negedge clk);
        blit_start_i = 1'b0;
        m_primed = 1'b0;
        check("R10 primed cleared", {15'h0, primed_o}, 16'h0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) mc[i] = '0;
        m_primed = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 out_vld", {15'h0, out_vld_o}, 16'h0);
        check("R1 primed", {15'h0, primed_o}, 16'h0);
        set_ctrl(5, 5, 1'b0);
        for (int p = 0; p < 4; p++) do_shift("R1 zero carry", p, 16'hA5C3, 1'b0);
    endtask

    task automatic t_asc_pos();
        set_ctrl(2, 5, 1'b0);
        do_start();
        do_shift("R3 asc first", 0, 16'hF00F, 1'b1);
        do_shift("R3 asc next", 0, 16'h8421, 1'b0);
        do_shift("R2 asc next", 0, 16'hFFFF, 1'b0);
        set_ctrl(7, 7, 1'b0);
        do_shift("R3 delta0", 0, 16'h1234, 1'b0);
        do_shift("R3 delta0 empty", 0, 16'h0000, 1'b0);
    endtask

    task automatic t_asc_neg();
        set_ctrl(9, 3, 1'b0);
        do_start();
        do_shift("R4 asc neg first", 3, 16'hBEEF, 1'b1);
        do_shift("R4 asc neg next", 3, 16'h1357, 1'b0);
        set_ctrl(15, 0, 1'b0);
        do_shift("R4 max L", 3, 16'hC001, 1'b0);
    endtask

    task automatic t_desc();
        set_ctrl(1, 12, 1'b1);
        do_start();
        do_shift("R5 desc pos first", 1, 16'hCAFE, 1'b1);
        do_shift("R5 desc pos next", 1, 16'h0F0F, 1'b0);
        set_ctrl(11, 4, 1'b1);
        do_shift("R5 desc neg", 1, 16'h7E81, 1'b0);
        do_shift("R2 desc neg next", 1, 16'hFFFF, 1'b0);
    endtask

    task automatic t_planes();
        set_ctrl(3, 10, 1'b0);
        do_start();
        do_shift("R6 p0", 0, 16'hFFFF, 1'b1);
        do_shift("R6 p1", 1, 16'h00FF, 1'b0);
        do_shift("R6 p2", 2, 16'hF0F0, 1'b0);
        do_shift("R6 p3", 3, 16'h1111, 1'b0);
        for (int p = 3; p >= 0; p--) do_shift("R6 readback", p, 16'h0000, 1'b0);
    endtask

    task automatic t_first_clear();
        set_ctrl(4, 6, 1'b0);
        for (int p = 0; p < 4; p++) do_shift("R7 fill", p, 16'hFFFF, 1'b0);
        do_start();
        do_shift("R7 first clears", 2, 16'hC000, 1'b1);
        for (int p = 0; p < 4; p++) do_shift("R7 after clear", p, 16'h0000, 1'b0);
    endtask

    task automatic t_prime();
        set_ctrl(12, 4, 1'b0);
        do_start();
        do_prime("R8 prime", 16'hABCD, 1'b0);
        do_shift("R8 first kept", 2, 16'h5555, 1'b1);
        do_shift("R8 bcast p0", 0, 16'h0000, 1'b0);
        do_shift("R8 bcast p3", 3, 16'h0000, 1'b0);
    endtask

    task automatic t_prime_ignored();
        do_prime("R9 already primed", 16'hFFFF, 1'b0);
        do_shift("R9 carry kept", 1, 16'h0000, 1'b0);
        set_ctrl(4, 12, 1'b0);
        do_start();
        do_shift("R9 load p2", 2, 16'hFFFF, 1'b0);
        do_prime("R9 src<=dst", 16'hFFFF, 1'b0);
        do_shift("R9 carry p2 kept", 2, 16'h0000, 1'b0);
        set_ctrl(12, 4, 1'b0);
        do_shift("R9 load p0", 0, 16'hF00F, 1'b0);
        do_prime("R9 with shift", 16'hFFFF, 1'b1);
        do_shift("R9 carry p0 kept", 0, 16'h0000, 1'b0);
    endtask

    task automatic t_start_keeps();
        set_ctrl(13, 2, 1'b1);
        do_start();
        do_prime("R10 prime", 16'h9009, 1'b0);
        do_start();
        do_shift("R10 carry kept", 3, 16'h0000, 1'b0);
    endtask

    initial begin
        t_reset();
        t_asc_pos();
        t_asc_neg();
        t_desc();
        t_planes();
        t_first_clear();
        t_prime();
        t_prime_ignored();
        t_start_keeps();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog act timeout exp done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule